// File: doc/BRIEF.md
# Burst-Addressed Synchronous Data RAM

This block is a synchronous word RAM for a processor's secondary cache. Each word is 72 bits wide, made of eight 9-bit lanes (eight data bits and one parity bit per lane). A two-bit burst counter inside the block steps through a four-word group, so the host sends one address per burst and then uses one control per cycle to move forward or wait. All controls and the external address are sampled on the rising clock edge. A write is committed on that edge. Read data flows through: it appears on the output in the same cycle as the edge that selected its address, with no pipeline register.

A burst starts when the address strobe is sampled low. If any lane write enable is low in that cycle the burst is a write, and if all of them are high it is a read. In later cycles a low count enable moves the counter one step. With both the strobe and the count enable high the current address is kept, which adds a wait state. The order of the four words is linear or interleaved, chosen by a mode input that is captured when the burst starts. A standby input deselects the block. The output driver is controlled by an asynchronous active-low output enable. The pad ring turns the pad-enable output into a high-impedance bus.

Top module: `burst_sram`

## Requirements
- R1: When `standbyIn` is 1 at a rising edge, that cycle performs no write and no read, whatever the other controls are. `rdOe` is 0 until a later read cycle, and the burst state is kept.
- R2: With `standbyIn` 0 and `addrStrobeN` 0, `addrIn` is loaded and the burst step becomes 0. The cycle is a write if any `byteWeN` bit is 0, and a read if all eight bits are 1.
- R3: With `standbyIn` 0, `addrStrobeN` 1 and `countEnN` 0, the burst step advances by one (modulo 4) and the read or write uses the new address.
- R4: With `standbyIn` 0, `addrStrobeN` 1 and `countEnN` 1, the address stays the same. A read repeats the same word, and a write overwrites the same word.
- R5: When `orderSel` is 0 at burst start, the low two address bits follow (base + step) mod 4.
- R6: When `orderSel` is 1 at burst start, the low two address bits follow base XOR step. The order is fixed at burst start, and later changes of `orderSel` have no effect until the next burst.
- R7: The address bits above bit 1 keep the value loaded at burst start, so a burst wraps inside its aligned four-word group.
- R8: `byteWeN[i]` is active low and controls only lane i, which is `wrData[9*i+8:9*i]`. Lanes whose enable is 1 keep their stored value.
- R9: After the rising edge that selects a read address, `rdData` shows the stored word combinationally. A word written at one edge is returned by a read of that address at the next edge.
- R10: `rdOe` is 1 only in a read cycle while `outEnN` is 0. It follows `outEnN` without a clock edge, and it is 0 in write cycles whatever the value of `outEnN`. `rdData` is 0 whenever `rdOe` is 0.
- R11: While `rstN` is low, and after reset until the first read cycle, `rdOe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset of the burst state |
| standbyIn | input | 1 | 1 deselects the block for the cycle |
| addrStrobeN | input | 1 | Active-low burst start, loads `addrIn` |
| countEnN | input | 1 | Active-low burst advance |
| byteWeN | input | 8 | Active-low lane write enables |
| orderSel | input | 1 | Burst order: 0 linear, 1 interleaved |
| addrIn | input | ADDR_W | External word address |
| wrData | input | 72 | Write word, eight 9-bit lanes |
| outEnN | input | 1 | Asynchronous active-low output enable |
| rdData | output | 72 | Flow-through read word, 0 when not driven |
| rdOe | output | 1 | Pad drive enable; 0 means the bus is high-impedance |

## Verification
Writes take effect at the sampling edge, so a write is only seen through the read cycle that follows it. Read data and `rdOe` are due in the same cycle as the edge that selected them, because no register sits after the memory. The bench drives inputs at the falling edge and samples the outputs 2 ns after each rising edge. For the asynchronous output enable, the bench changes `outEnN` between edges and samples 1 ns later, without a clock edge.

// File: rtl/burst_pkg.sv
package burst_pkg;
  typedef enum logic [1:0] {
    CYC_IDLE  = 2'd0,
    CYC_BEGIN = 2'd1,
    CYC_NEXT  = 2'd2,
    CYC_HOLD  = 2'd3
  } cycKind_t;

  typedef struct packed {
    logic wrStrobe;  // commit lanes at this edge
    logic rdValid;   // registered: current cycle is a read
  } ramStrobes_t;
endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              standbyIn,
  input  logic              addrStrobeN,
  input  logic              countEnN,
  input  logic [LANES-1:0]  byteWeN,
  input  logic              orderSel,
  input  logic [ADDR_W-1:0] addrIn,
  output ramStrobes_t       strobes,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] rdAddr
);
  localparam int UP_W = ADDR_W - 2;

  logic [UP_W-1:0] upperQ, upperD;
  logic [1:0]      baseQ, baseD, stepQ, stepD, lowD, lowQ;
  logic            orderQ, orderD, rdValidQ;
  logic            anyWrite;
  cycKind_t        cycKind;

  assign anyWrite = ~&byteWeN;

  always_comb begin
    if (standbyIn)         cycKind = CYC_IDLE;
    else if (!addrStrobeN) cycKind = CYC_BEGIN;
    else if (!countEnN)    cycKind = CYC_NEXT;
    else                   cycKind = CYC_HOLD;
  end

  always_comb begin
    upperD = upperQ;
    baseD  = baseQ;
    stepD  = stepQ;
    orderD = orderQ;
    case (cycKind)
      CYC_BEGIN: begin
        upperD = addrIn[ADDR_W-1:2];
        baseD  = addrIn[1:0];
        stepD  = 2'd0;
        orderD = orderSel;
      end
      CYC_NEXT: stepD = stepQ + 2'd1;
      default: ;
    endcase
  end

  assign lowD   = orderD ? (baseD ^ stepD) : (baseD + stepD);
  assign lowQ   = orderQ ? (baseQ ^ stepQ) : (baseQ + stepQ);
  assign wrAddr = {upperD, lowD};
  assign rdAddr = {upperQ, lowQ};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      upperQ   <= '0;
      baseQ    <= 2'd0;
      stepQ    <= 2'd0;
      orderQ   <= 1'b0;
      rdValidQ <= 1'b0;
    end else begin
      upperQ   <= upperD;
      baseQ    <= baseD;
      stepQ    <= stepD;
      orderQ   <= orderD;
      rdValidQ <= (cycKind != CYC_IDLE) && !anyWrite;
    end
  end

  assign strobes.wrStrobe = (cycKind != CYC_IDLE) && anyWrite;
  assign strobes.rdValid  = rdValidQ;

  // R1: a deselected edge never leaves a read cycle behind
  assert_deselect_R1: assert property (@(posedge clk) disable iff (!rstN)
    standbyIn |=> !strobes.rdValid);

  // R3: an advance moves the step by exactly one
  assert_advance_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!standbyIn && addrStrobeN && !countEnN) |=> (stepQ == $past(stepQ) + 2'd1));

  // R4: a suspend keeps the selected address
  assert_suspend_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!standbyIn && addrStrobeN && countEnN) |=> $stable(rdAddr));

  // R7: the upper address bits only change on a burst start
  assert_upper_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    addrStrobeN |=> $stable(upperQ));
endmodule

// File: rtl/burst_data.sv
module burst_data
  import burst_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 8,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ramStrobes_t             strobes,
  input  logic [ADDR_W-1:0]       wrAddr,
  input  logic [ADDR_W-1:0]       rdAddr,
  input  logic [LANES-1:0]        byteWeN,
  input  logic [LANES*LANE_W-1:0] wrData,
  input  logic                    outEnN,
  output logic [LANES*LANE_W-1:0] rdData,
  output logic                    rdOe
);
  localparam int WORD_W = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [WORD_W-1:0] memArr [DEPTH];

  always_ff @(posedge clk) begin
    if (strobes.wrStrobe) begin
      for (int l = 0; l < LANES; l++) begin
        if (!byteWeN[l]) memArr[wrAddr][l*LANE_W +: LANE_W] <= wrData[l*LANE_W +: LANE_W];
      end
    end
  end

  assign rdOe   = strobes.rdValid && !outEnN;
  assign rdData = rdOe ? memArr[rdAddr] : '0;

  // R10: a write edge is never followed by a driven output
  assert_no_drive_after_write_R10: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrStrobe |=> !rdOe);
endmodule

// File: rtl/burst_sram.sv
module burst_sram
  import burst_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 8,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    standbyIn,
  input  logic                    addrStrobeN,
  input  logic                    countEnN,
  input  logic [LANES-1:0]        byteWeN,
  input  logic                    orderSel,
  input  logic [ADDR_W-1:0]       addrIn,
  input  logic [LANES*LANE_W-1:0] wrData,
  input  logic                    outEnN,
  output logic [LANES*LANE_W-1:0] rdData,
  output logic                    rdOe
);
  ramStrobes_t       strobes;
  logic [ADDR_W-1:0] wrAddr, rdAddr;

  burst_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) uCtrl (
    .clk(clk), .rstN(rstN), .standbyIn(standbyIn), .addrStrobeN(addrStrobeN),
    .countEnN(countEnN), .byteWeN(byteWeN), .orderSel(orderSel), .addrIn(addrIn),
    .strobes(strobes), .wrAddr(wrAddr), .rdAddr(rdAddr)
  );

  burst_data #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .byteWeN(byteWeN), .wrData(wrData), .outEnN(outEnN), .rdData(rdData), .rdOe(rdOe)
  );
endmodule

// File: tb/sim_burst_sram.sv
module sim_burst_sram;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        standbyIn = 1'b1, addrStrobeN = 1'b1, countEnN = 1'b1, orderSel = 1'b0, outEnN = 1'b1;
  logic [7:0]  byteWeN = 8'hFF;
  logic [7:0]  addrIn = '0;
  logic [71:0] wrData = '0;
  logic [71:0] rdData;
  logic        rdOe;

  int testsRun = 0, testsFail = 0;
  bit done = 0;

  // behavioural reference state
  logic [71:0] refMem [int];
  int mUpper = 0, mBase = 0, mStep = 0, mOrder = 0, mRdv = 0, mRdAddr = 0;

  always #10 clk = ~clk;

  burst_sram u0 (
    .clk(clk), .rstN(rstN), .standbyIn(standbyIn), .addrStrobeN(addrStrobeN),
    .countEnN(countEnN), .byteWeN(byteWeN), .orderSel(orderSel), .addrIn(addrIn),
    .wrData(wrData), .outEnN(outEnN), .rdData(rdData), .rdOe(rdOe)
  );

  function automatic logic [71:0] pat(int a);
    return {8{9'(a * 7 + 3)}} ^ 72'hA5_3C96_E1D2_4B78_0F1E;
  endfunction

  task automatic compare(string tag);
    logic        expOe;
    logic [71:0] expData;
    expOe   = (mRdv != 0) && !outEnN;
    expData = expOe ? refMem[mRdAddr] : 72'd0;
    testsRun++;
    if (rdOe !== expOe || rdData !== expData) begin
      testsFail++;
      $display("FAIL %s: rdOe=%0b rdData=%h expected rdOe=%0b rdData=%h", tag, rdOe, rdData, expOe, expData);
    end
  endtask

  task automatic step(input logic sb, input logic as, input logic cen, input logic [7:0] we,
                      input logic ord, input logic [7:0] addr, input logic [71:0] data,
                      input logic oe, input string tag);
    int a;
    @(negedge clk);
    standbyIn = sb; addrStrobeN = as; countEnN = cen; byteWeN = we;
    orderSel = ord; addrIn = addr; wrData = data; outEnN = oe;
    if (sb) mRdv = 0;
    else begin
      if (!as) begin
        mUpper = addr / 4; mBase = addr % 4; mStep = 0; mOrder = ord;
      end else if (!cen) mStep = (mStep + 1) % 4;
      a = mUpper * 4 + (mOrder != 0 ? (mBase ^ mStep) : ((mBase + mStep) % 4));
      if (we != 8'hFF) begin
        logic [71:0] w;
        w = refMem.exists(a) ? refMem[a] : 72'd0;
        for (int l = 0; l < 8; l++) if (!we[l]) w[l*9 +: 9] = data[l*9 +: 9];
        refMem[a] = w;
        mRdv = 0;
      end else begin
        mRdv = 1; mRdAddr = a;
      end
    end
    @(posedge clk);
    #2;
    compare(tag);
  endtask

  initial begin
    #(20 * 200000);
    testsFail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFail);
    $finish;
  end

  initial begin
    // R11: reset state
    repeat (3) @(posedge clk);
    #2; compare("R11 in reset");
    @(negedge clk); rstN = 1'b1; outEnN = 1'b0;
    @(posedge clk); #2; compare("R11 after reset");

    // R2 R3 R5: linear write burst covering 0x10..0x13 and 0x20..0x23
    step(0, 0, 1, 8'h00, 0, 8'h10, pat(16), 0, "R2 write begin");
    for (int i = 1; i < 4; i++) step(0, 1, 0, 8'h00, 0, 8'h00, pat(16 + i), 0, "R3 write advance");
    step(0, 0, 1, 8'h00, 0, 8'h20, pat(32), 0, "R2 write begin");
    for (int i = 1; i < 4; i++) step(0, 1, 0, 8'h00, 0, 8'h00, pat(32 + i), 0, "R3 write advance");

    // R5 R7: linear read from 0x12 wraps to 0x10 inside the group
    step(0, 0, 1, 8'hFF, 0, 8'h12, '0, 0, "R2 R9 read begin");
    for (int i = 1; i < 4; i++) step(0, 1, 0, 8'hFF, 0, 8'h00, '0, 0, "R5 R7 linear wrap");

    // R6: interleaved read from 0x23, order change mid-burst ignored
    step(0, 0, 1, 8'hFF, 1, 8'h23, '0, 0, "R6 interleave begin");
    step(0, 1, 0, 8'hFF, 1, 8'h00, '0, 0, "R6 interleave step");
    step(0, 1, 0, 8'hFF, 0, 8'h00, '0, 0, "R6 order latched");
    step(0, 1, 0, 8'hFF, 0, 8'h00, '0, 0, "R6 order latched");

    // R4: suspend during read
    step(0, 0, 1, 8'hFF, 0, 8'h11, '0, 0, "R4 read begin");
    step(0, 1, 1, 8'hFF, 0, 8'h00, '0, 0, "R4 read wait");
    step(0, 1, 1, 8'hFF, 0, 8'h00, '0, 0, "R4 read wait");
    step(0, 1, 0, 8'hFF, 0, 8'h00, '0, 0, "R4 resume");

    // R4: suspend during write overwrites same word
    step(0, 0, 1, 8'h00, 0, 8'h30, pat(48), 0, "R4 write begin");
    step(0, 1, 1, 8'h00, 0, 8'h00, pat(99), 0, "R4 write wait");
    step(0, 1, 0, 8'h00, 0, 8'h00, pat(49), 0, "R4 write resume");
    step(0, 0, 1, 8'hFF, 0, 8'h30, '0, 0, "R4 read back");
    step(0, 1, 0, 8'hFF, 0, 8'h00, '0, 0, "R4 read back");

    // R8: partial lanes
    step(0, 0, 1, 8'b1010_0101, 0, 8'h10, ~pat(7), 0, "R8 lane write");
    step(0, 0, 1, 8'hFF, 0, 8'h10, '0, 0, "R8 lane read");
    step(0, 0, 1, 8'b0111_1110, 0, 8'h11, 72'h0, 0, "R8 lane write");
    step(0, 0, 1, 8'hFF, 0, 8'h11, '0, 0, "R8 lane read");

    // R1: standby blocks write even with strobe and enables low
    step(1, 0, 0, 8'h00, 0, 8'h12, pat(200), 0, "R1 deselected write");
    step(0, 0, 1, 8'hFF, 0, 8'h12, '0, 0, "R1 word kept");
    step(1, 1, 0, 8'hFF, 0, 8'h00, '0, 0, "R1 mid-burst standby");
    step(0, 1, 0, 8'hFF, 0, 8'h00, '0, 0, "R1 burst state kept");

    // R9: flow-through read right after write
    step(0, 0, 1, 8'h00, 0, 8'h40, pat(64), 0, "R9 write");
    step(0, 0, 1, 8'hFF, 0, 8'h40, '0, 0, "R9 read after write");

    // R10: output enable
    step(0, 0, 1, 8'hFF, 0, 8'h21, '0, 1, "R10 read with oe high");
    #1; outEnN = 1'b0; #1; compare("R10 async enable");
    #1; outEnN = 1'b1; #1; compare("R10 async disable");
    step(0, 0, 1, 8'h00, 0, 8'h41, pat(65), 0, "R10 write with oe low");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFail);
    $finish;
  end
endmodule